// File: doc/BRIEF.md
# Supply Lockout and Auto-Restart Sequencer

This block supervises the start-up and fault recovery of an off-line flyback controller. Analog comparators outside the block report seven conditions as flags:
- supply above its turn-on level;
- supply below its turn-off level;
- supply overvoltage;
- soft-start ramp complete;
- soft-start above the overvoltage-window limit;
- feedback above the overload limit;
- junction over-temperature.

From these flags the block derives four controls: a bias enable, a soft-start capacitor discharge, a power-switch gate enable and an error-latch status. It also exposes its sequencing state.

Operation follows a hysteretic lockout. The block wakes when the supply crosses the upper level and sleeps only when the supply falls under the lower one. Waking clears the error latch. Sleeping discharges the soft-start capacitor, so every start ramps from zero. Two fault windows depend on the ramp:
- Overload is armed only once the ramp has completed.
- Supply overvoltage is armed only while the ramp is still low and the feedback is high.

Over-temperature is armed in every active state. A fault must hold for a blanking interval before it sets the latch. The latched fault stops the gate until the supply has collapsed and returned, and that supply cycle is the auto-restart burst.

Top module: `psu_restart_seq`

## Requirements
- R1: During and right after reset the state code is 0 (OFF), bias_en is 0, ss_discharge is 1, gate_en is 0 and err_latched is 0.
- R2: In OFF, a high supply-on flag moves the block to SOFTSTART (code 1), with bias_en 1, ss_discharge 0 and gate_en 1.
- R3: An active block stays active while the supply-on flag is low and the supply-off flag is low. A high supply-off flag returns it to OFF with ss_discharge 1 and bias_en 0.
- R4: High feedback has no effect in SOFTSTART. A high soft-start-done flag moves SOFTSTART to RUN (code 2) with the gate still enabled.
- R5: When the soft-start-done flag and the feedback flag have both been high for BLANK_CYC consecutive synchronised cycles, the block enters FAULT (code 3), err_latched becomes 1 and gate_en becomes 0. After BLANK_CYC-1 such cycles it is still in RUN.
- R6: A fault condition that drops before BLANK_CYC cycles restarts the blanking count, so two such pulses separated by one quiet cycle never set the latch.
- R7: Supply overvoltage sets the latch after blanking only while the feedback flag is high and the overvoltage-window flag is low. It is ignored while the window flag is high.
- R8: Over-temperature held for the blanking time sets the latch from any active state.
- R9: Once set, err_latched and FAULT persist while the fault inputs clear. err_latched stays 1 through OFF and is cleared only when the next activation enters SOFTSTART.
- R10: state_dbg encodes OFF=0, SOFTSTART=1, RUN=2, FAULT=3.
- R11: Every flag passes two synchronising flops. A flag applied before a rising edge first affects the outputs after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_off_i | input | 1 | Supply below turn-off level |
| vcc_ovp_i | input | 1 | Supply above overvoltage level |
| ss_done_i | input | 1 | Soft-start ramp above activation level |
| ss_win_i | input | 1 | Soft-start ramp above overvoltage-window limit |
| fb_high_i | input | 1 | Feedback above overload limit |
| hot_i | input | 1 | Junction over-temperature |
| bias_en | output | 1 | Internal bias and reference enable |
| ss_discharge | output | 1 | Soft-start capacitor discharge |
| gate_en | output | 1 | Power-switch gate enable |
| err_latched | output | 1 | Error latch status |
| state_dbg | output | 2 | Current sequencing state code |

## Verification
A corrupted state register shows at once on state_dbg and on the enable pattern, because bias, discharge and gate are decoded directly from it. A wrong blanking count shows as a FAULT entry one or more cycles away from the exact expected edge, and the per-cycle reference comparison catches that. A latch that clears early or late shows as err_latched differing from the model during the OFF interval or on the first SOFTSTART cycle. A synchroniser with the wrong depth shifts every transition by a cycle, so the first activation already exposes it.

// File: rtl/psu_restart_seq.sv
module psu_restart_seq #(
  parameter int CLK_HZ   = 125_000_000,
  parameter int BLANK_NS = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on_i,
  input  logic       vcc_off_i,
  input  logic       vcc_ovp_i,
  input  logic       ss_done_i,
  input  logic       ss_win_i,
  input  logic       fb_high_i,
  input  logic       hot_i,
  output logic       bias_en,
  output logic       ss_discharge,
  output logic       gate_en,
  output logic       err_latched,
  output logic [1:0] state_dbg
);
  localparam int BLANK_CYC = (CLK_HZ / 1000) * BLANK_NS / 1_000_000;
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam int NF = 7;

  typedef enum logic [1:0] {S_OFF = 2'd0, S_SS = 2'd1, S_RUN = 2'd2, S_FLT = 2'd3} st_t;

  logic [NF-1:0] meta, sy;
  st_t           st;
  logic [CW-1:0] cnt;
  logic          err_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= '0;
      sy   <= '0;
    end else begin
      meta <= {hot_i, fb_high_i, ss_win_i, ss_done_i, vcc_ovp_i, vcc_off_i, vcc_on_i};
      sy   <= meta;
    end

  wire on_s  = sy[0];
  wire off_s = sy[1];
  wire ovp_s = sy[2];
  wire ssd_s = sy[3];
  wire win_s = sy[4];
  wire fb_s  = sy[5];
  wire hot_s = sy[6];

  wire active = (st == S_SS) || (st == S_RUN);
  wire cond   = active && (hot_s || (ssd_s && fb_s) || (ovp_s && fb_s && !win_s));
  wire trip   = cond && (cnt == CW'(BLANK_CYC - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_OFF;
      cnt   <= '0;
      err_q <= 1'b0;
    end else begin
      cnt <= (cond && !off_s && !trip) ? cnt + 1'b1 : '0;
      case (st)
        S_OFF: if (on_s) begin
          st    <= S_SS;
          err_q <= 1'b0;
        end
        S_SS, S_RUN: begin
          if (off_s) st <= S_OFF;
          else if (trip) begin
            st    <= S_FLT;
            err_q <= 1'b1;
          end else if (st == S_SS && ssd_s) st <= S_RUN;
        end
        default: if (off_s) st <= S_OFF;
      endcase
    end

  assign bias_en      = st != S_OFF;
  assign ss_discharge = st == S_OFF;
  assign gate_en      = active;
  assign err_latched  = err_q;
  assign state_dbg    = st;
endmodule

// File: rtl/psu_restart_seq_chk.sv
module psu_restart_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bias_en,
  input logic       ss_discharge,
  input logic       gate_en,
  input logic       err_latched,
  input logic [1:0] state_dbg
);
  // R5
  gate_off_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_latched && state_dbg != 2'd0 |-> !gate_en);

  // R3
  discharge_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_discharge |-> !gate_en && !bias_en);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_latched |=> err_latched || (state_dbg == 2'd1 && $past(state_dbg) == 2'd0));

  // R4
  no_run_from_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_dbg == 2'd0 |=> state_dbg == 2'd0 || state_dbg == 2'd1);

  // R10
  fault_has_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_dbg == 2'd3 |-> err_latched);
endmodule

bind psu_restart_seq psu_restart_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bias_en(bias_en), .ss_discharge(ss_discharge),
  .gate_en(gate_en), .err_latched(err_latched), .state_dbg(state_dbg)
);

// File: tb/psu_restart_seq_tb.sv
module psu_restart_seq_tb;
  localparam int B = 5000 / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on = 0, off = 0, ovp = 0, ssd = 0, win = 0, fb = 0, hot = 0;
  logic bias_en, ss_discharge, gate_en, err_latched;
  logic [1:0] state_dbg;

  int n_run = 0, n_fail = 0;
  string cur = "R1";

  always #4 clk = ~clk;

  psu_restart_seq u_dut (
    .clk(clk), .rst_n(rst_n), .vcc_on_i(on), .vcc_off_i(off), .vcc_ovp_i(ovp),
    .ss_done_i(ssd), .ss_win_i(win), .fb_high_i(fb), .hot_i(hot),
    .bias_en(bias_en), .ss_discharge(ss_discharge), .gate_en(gate_en),
    .err_latched(err_latched), .state_dbg(state_dbg)
  );

  // reference model
  logic [6:0] q1 = '0, q2 = '0;
  int ms = 0, mc = 0;
  bit me = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q1 = '0; q2 = '0; ms = 0; mc = 0; me = 0;
    end else begin
      bit c;
      c = (ms == 1 || ms == 2) && (q2[6] || (q2[3] && q2[5]) || (q2[2] && q2[5] && !q2[4]));
      if (ms == 0) begin
        mc = 0;
        if (q2[0]) begin ms = 1; me = 0; end
      end else if (ms == 3) begin
        mc = 0;
        if (q2[1]) ms = 0;
      end else if (q2[1]) begin
        ms = 0; mc = 0;
      end else if (c && mc == B - 1) begin
        ms = 3; me = 1; mc = 0;
      end else begin
        mc = c ? mc + 1 : 0;
        if (ms == 1 && q2[3]) ms = 2;
      end
      q2 = q1;
      q1 = {hot, fb, win, ssd, ovp, off, on};
    end
  end

  always @(negedge clk) if (rst_n) begin
    n_run++;
    if (state_dbg != ms[1:0] || err_latched != me || gate_en != (ms == 1 || ms == 2) ||
        bias_en != (ms != 0) || ss_discharge != (ms == 0)) begin
      n_fail++;
      $display("FAIL %s model: state=%0d err=%0b gate=%0b exp state=%0d err=%0b",
               cur, state_dbg, err_latched, gate_en, ms, me);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    // R1 R10
    chk("R1 state", state_dbg, 0);
    chk("R1 outs", {bias_en, ss_discharge, gate_en, err_latched}, 4'b0100);
    rst_n = 1'b1;
    tick(2);
    chk("R1 after reset", {bias_en, ss_discharge, gate_en, err_latched}, 4'b0100);

    cur = "R11";
    on = 1; tick(2);
    chk("R11 not yet active", state_dbg, 0);
    tick(1);
    cur = "R2";
    chk("R2 state SOFTSTART", state_dbg, 1);
    chk("R2 outs", {bias_en, ss_discharge, gate_en}, 3'b101);

    cur = "R3";
    on = 0; tick(10);
    chk("R3 hysteresis hold", state_dbg, 1);

    cur = "R4";
    fb = 1; tick(2 * B);
    chk("R4 overload disarmed", {state_dbg, err_latched}, 3'b010);
    fb = 0; ssd = 1; win = 1; tick(3);
    chk("R4 RUN", {state_dbg, gate_en}, 3'b101);

    cur = "R6";
    fb = 1; tick(B - 1); fb = 0; tick(1); fb = 1; tick(B - 1); fb = 0; tick(5);
    chk("R6 spikes ignored", {state_dbg, err_latched}, 3'b100);

    cur = "R5";
    fb = 1; tick(B + 1);
    chk("R5 still RUN at B-1", state_dbg, 2);
    tick(1);
    chk("R5 FAULT", {state_dbg, err_latched, gate_en}, 4'b1110);
    fb = 0; ssd = 0; win = 0;

    cur = "R9";
    tick(20);
    chk("R9 FAULT holds", {state_dbg, err_latched}, 3'b111);
    off = 1; tick(3);
    chk("R9 OFF keeps err", {state_dbg, err_latched}, 3'b001);
    chk("R3 discharge", {ss_discharge, bias_en}, 2'b10);
    off = 0; on = 1; tick(3);
    chk("R9 cleared on activation", {state_dbg, err_latched}, 3'b010);
    on = 0;

    cur = "R7";
    ovp = 1; fb = 1; win = 1; tick(B + 5);
    chk("R7 ovp masked by window", {state_dbg, err_latched}, 3'b010);
    win = 0; tick(B + 1);
    chk("R7 not yet", state_dbg, 1);
    tick(1);
    chk("R7 ovp fault", {state_dbg, err_latched}, 3'b111);
    ovp = 0; fb = 0;

    cur = "R8";
    off = 1; tick(3); off = 0; on = 1; tick(3); on = 0;
    ssd = 1; win = 1; tick(3);
    chk("R8 RUN before", state_dbg, 2);
    hot = 1; tick(B + 2);
    chk("R8 thermal fault", {state_dbg, err_latched}, 3'b111);
    hot = 0; tick(5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule